// File: doc/BRIEF.md
# VCO Output Clock Divider Tree

This block turns a single fast oscillator clock into two slower clocks: a byte clock and a pixel clock. The pixel clock comes from one programmable counter running on the oscillator. The byte clock runs through a longer chain. A programmable post-divider feeds a fixed halving stage. A two-way select then picks either that halved path or the raw oscillator, and a fixed divide-by-four stage follows it.

Every register and output lives in the oscillator clock domain, so each output is a flip-flop output and cannot glitch. Software sets three configuration fields through a small write port: the post-divider ratio, the byte-path select and the pixel ratio. A save strobe copies all three fields into a shadow set. A restore strobe copies the shadow set back into the live fields in one cycle. A new ratio is never applied in the middle of an output period. A new select value is adopted only at a byte-clock boundary.

Top module: `vco_out_divtree`

## Requirements
- R1: After reset all three fields are zero. byte_clk is low and then runs with a period of 4 oscillator cycles, 2 high and 2 low. pix_clk is high.
- R2: A write with cfg_we high sets a field from cfg_wdata, chosen by cfg_addr. Address 0 sets the post-divider ratio P from bits [3:0]. Address 1 sets the byte select S from bit 1. Address 2 sets the pixel ratio D from bits [7:0].
- R3: With S = 0, byte_clk has a period of 4 oscillator cycles and is high for 2 of them.
- R4: With S = 1, byte_clk has a period of 8*(P+1) oscillator cycles and is high for half of it.
- R5: With D >= 1, pix_clk has a period of D+1 oscillator cycles and is high for ceil((D+1)/2) of them.
- R6: With D = 0, pix_clk stays high. This is the divide-by-1 case.
- R7: A new pixel ratio takes effect only after the pixel period in progress completes at the old ratio. The post-divider ratio behaves the same way at its own terminal count.
- R8: A new select value is adopted when byte_clk falls. The high phase in progress finishes at the old rate, and the following low phase already runs at the new rate. No byte_clk high or low phase is ever shorter than 2 oscillator cycles.
- R9: save_i copies P, S and D into a shadow set. restore_i writes the shadow set back into the live fields, and it takes precedence over a write in the same cycle.
- R10: A write to address 3 changes none of the fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Oscillator clock; every register uses it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Field select for the write |
| cfg_wdata | input | 8 | Write data |
| save_i | input | 1 | Copy the live fields into the shadow set |
| restore_i | input | 1 | Copy the shadow set into the live fields |
| byte_clk | output | 1 | Byte clock output |
| pix_clk | output | 1 | Pixel clock output |

## Verification
The bench pushes both ratios to their extremes, P = 15 and D = 255, and to the degenerate D = 0. A counter with an off-by-one at its terminal count would give periods one cycle long or short at those points. A design with no bypass handling would toggle pix_clk instead of holding it high. Two more checks rewrite the pixel ratio and the select right after a rising edge. A design that applied the pixel ratio at once would shorten that pixel period, and a select that switched at once would cut the byte high phase short. Restore is also issued in the same cycle as a pixel write; getting that precedence wrong leaves the written ratio live.

// File: rtl/vdt_pkg.sv
package vdt_pkg;
    // write addresses of the three configuration fields
    typedef enum logic [1:0] {
        ADDR_POST = 2'd0,
        ADDR_SEL  = 2'd1,
        ADDR_PIX  = 2'd2,
        ADDR_NONE = 2'd3
    } cfg_addr_e;

    // bit of the select write data that carries the select
    localparam int SEL_BIT = 1;
endpackage

// File: rtl/vdt_cfg_regs.sv
module vdt_cfg_regs #(
    parameter int POST_W = 4,
    parameter int PIX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              save,
    input  logic              restore,
    output logic [POST_W-1:0] post_ratio,
    output logic              sel,
    output logic [PIX_W-1:0]  pix_ratio
);
    import vdt_pkg::*;

    typedef struct packed {
        logic [POST_W-1:0] post;
        logic              sel;
        logic [PIX_W-1:0]  pix;
    } fields_t;

    typedef struct packed {
        fields_t live;
        fields_t shadow;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (save) begin
            st_d.shadow = st_q.live;
        end
        if (restore) begin
            st_d.live = st_q.shadow;
        end else if (we) begin
            case (cfg_addr_e'(addr))
                ADDR_POST: st_d.live.post = wdata[POST_W-1:0];
                ADDR_SEL:  st_d.live.sel  = wdata[SEL_BIT];
                ADDR_PIX:  st_d.live.pix  = wdata[PIX_W-1:0];
                default:   st_d.live      = st_q.live;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign post_ratio = st_q.live.post;
    assign sel        = st_q.live.sel;
    assign pix_ratio  = st_q.live.pix;
endmodule

// File: rtl/vdt_pix_div.sv
module vdt_pix_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ratio,
    output logic         clk_out
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] act;
        logic         lvl;
    } st_t;

    st_t        st_d, st_q;
    logic [W:0] hi_len;

    always_comb begin
        st_d = st_q;
        // the ratio is reloaded only at terminal count
        if (st_q.cnt == st_q.act) begin
            st_d.cnt = '0;
            st_d.act = ratio;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        // high for ceil((act+1)/2) cycles of each period
        hi_len   = ({1'b0, st_d.act} + (W+1)'(2)) >> 1;
        st_d.lvl = ({1'b0, st_d.cnt} < hi_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, act: '0, lvl: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_out = st_q.lvl;
endmodule

// File: rtl/vdt_byte_path.sv
module vdt_byte_path #(
    parameter int POST_W = 4,
    parameter int BCW    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POST_W-1:0] post_ratio,
    input  logic              sel_req,
    output logic              clk_out
);
    typedef struct packed {
        logic [POST_W-1:0] pcnt;
        logic [POST_W-1:0] pact;
        logic              half;
        logic              sel;
        logic [BCW-1:0]    bcnt;
    } st_t;

    st_t  st_d, st_q;
    logic post_wrap;
    logic half_tick;
    logic adv;

    always_comb begin
        st_d      = st_q;
        post_wrap = st_q.sel && (st_q.pcnt == st_q.pact);
        half_tick = post_wrap && st_q.half;

        // post-divider and halving stage; held idle while the raw path is chosen
        if (!st_q.sel) begin
            st_d.pcnt = '0;
            st_d.half = 1'b0;
            st_d.pact = post_ratio;
        end else if (post_wrap) begin
            st_d.pcnt = '0;
            st_d.pact = post_ratio;
            st_d.half = ~st_q.half;
        end else begin
            st_d.pcnt = st_q.pcnt + 1'b1;
        end

        // source select feeding the fixed final divider
        adv = st_q.sel ? half_tick : 1'b1;
        if (adv) begin
            st_d.bcnt = st_q.bcnt + 1'b1;
            if (&st_q.bcnt) begin
                st_d.sel = sel_req;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_out = st_q.bcnt[BCW-1];
endmodule

// File: rtl/vco_out_divtree.sv
module vco_out_divtree #(
    parameter int POST_W = 4,
    parameter int PIX_W  = 8,
    parameter int DATA_W = 8,
    parameter int BCW    = 2
) (
    input  logic              clk_vco,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              save_i,
    input  logic              restore_i,
    output logic              byte_clk,
    output logic              pix_clk
);
    logic [POST_W-1:0] post_cfg;
    logic              sel_cfg;
    logic [PIX_W-1:0]  pix_cfg;

    vdt_cfg_regs #(
        .POST_W(POST_W),
        .PIX_W (PIX_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk_vco),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .save      (save_i),
        .restore   (restore_i),
        .post_ratio(post_cfg),
        .sel       (sel_cfg),
        .pix_ratio (pix_cfg)
    );

    vdt_byte_path #(
        .POST_W(POST_W),
        .BCW   (BCW)
    ) u_byte (
        .clk       (clk_vco),
        .rst_n     (rst_n),
        .post_ratio(post_cfg),
        .sel_req   (sel_cfg),
        .clk_out   (byte_clk)
    );

    vdt_pix_div #(
        .W(PIX_W)
    ) u_pix (
        .clk    (clk_vco),
        .rst_n  (rst_n),
        .ratio  (pix_cfg),
        .clk_out(pix_clk)
    );
endmodule

// File: rtl/vdt_chk.sv
module vdt_chk #(
    parameter int POST_W = 4,
    parameter int PIX_W  = 8,
    parameter int DATA_W = 8
) (
    input logic              clk_vco,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [1:0]        cfg_addr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic              restore_i,
    input logic              byte_clk,
    input logic [POST_W-1:0] post_cfg,
    input logic              sel_cfg,
    input logic [PIX_W-1:0]  pix_cfg
);
    // R2
    post_write_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
        (cfg_we && !restore_i && cfg_addr == 2'd0) |=> (post_cfg == $past(cfg_wdata[POST_W-1:0])));

    // R2
    sel_write_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
        (cfg_we && !restore_i && cfg_addr == 2'd1) |=> (sel_cfg == $past(cfg_wdata[1])));

    // R2
    pix_write_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
        (cfg_we && !restore_i && cfg_addr == 2'd2) |=> (pix_cfg == $past(cfg_wdata[PIX_W-1:0])));

    // R10
    addr3_ignored_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
        (cfg_we && !restore_i && cfg_addr == 2'd3) |=> ($stable(post_cfg) && $stable(sel_cfg) && $stable(pix_cfg)));

    // R8
    byte_high_min_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
        $rose(byte_clk) |=> byte_clk);

    // R8
    byte_low_min_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
        $fell(byte_clk) |=> !byte_clk);
endmodule

bind vco_out_divtree vdt_chk #(
    .POST_W(POST_W),
    .PIX_W (PIX_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk_vco  (clk_vco),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .restore_i(restore_i),
    .byte_clk (byte_clk),
    .post_cfg (post_cfg),
    .sel_cfg  (sel_cfg),
    .pix_cfg  (pix_cfg)
);

// File: tb/vco_out_divtree_test.sv
`timescale 1ns/1ps
module vco_out_divtree_test;
    logic       clk_vco = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       save_i = 1'b0;
    logic       restore_i = 1'b0;
    logic       byte_clk;
    logic       pix_clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk_vco = ~clk_vco;

    vco_out_divtree uut (
        .clk_vco  (clk_vco),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .save_i   (save_i),
        .restore_i(restore_i),
        .byte_clk (byte_clk),
        .pix_clk  (pix_clk)
    );

    // stimulus table: post ratio, select, pixel ratio
    localparam int NV = 8;
    localparam int V_POST [NV] = '{0, 0, 3, 15, 7, 1, 5, 15};
    localparam int V_SEL  [NV] = '{0, 1, 1, 1,  0, 1, 1, 0};
    localparam int V_PIX  [NV] = '{1, 2, 3, 255, 10, 0, 127, 4};

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic sig(input bit pix);
        return pix ? pix_clk : byte_clk;
    endfunction

    task automatic wr(input int a, input int d);
        cfg_we    = 1'b1;
        cfg_addr  = 2'(a);
        cfg_wdata = 8'(d);
        @(negedge clk_vco);
        cfg_we = 1'b0;
    endtask

    task automatic settle();
        repeat (700) @(negedge clk_vco);
    endtask

    task automatic wait_rise(input bit pix);
        logic prev;
        prev = sig(pix);
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk_vco);
            if (!prev && sig(pix)) break;
            prev = sig(pix);
        end
    endtask

    // counts from a rise just seen to the next rise; clears cfg_we after the first cycle
    task automatic count_period(input bit pix, output int per, output int hi);
        logic prev;
        per  = 1;
        hi   = 1;
        prev = 1'b1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk_vco);
            cfg_we = 1'b0;
            if (!prev && sig(pix)) break;
            per++;
            if (sig(pix)) hi++;
            prev = sig(pix);
        end
    endtask

    task automatic measure(input bit pix, output int per, output int hi);
        wait_rise(pix);
        count_period(pix, per, hi);
    endtask

    task automatic hold_high(input string req, input int cycles);
        int lows;
        lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk_vco);
            if (!pix_clk) lows++;
        end
        check(req, "pix_clk low cycles with D=0", lows, 0);
    endtask

    task automatic check_byte(input string req, input int p, input int s);
        int per, hi, exp;
        exp = (s != 0) ? 8 * (p + 1) : 4;
        measure(1'b0, per, hi);
        check(req, "byte period", per, exp);
        check(req, "byte high", hi, exp / 2);
    endtask

    task automatic check_pix(input string req, input int d);
        int per, hi;
        if (d == 0) begin
            hold_high("R6", 300);
        end else begin
            measure(1'b1, per, hi);
            check(req, "pix period", per, d + 1);
            check(req, "pix high", hi, (d + 2) / 2);
        end
    endtask

    task automatic run_lengths(input int cycles);
        int   len, runs, shortest;
        logic prev;
        len = 0; runs = 0; shortest = 99;
        prev = byte_clk;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk_vco);
            len++;
            if (byte_clk != prev) begin
                if (runs > 0 && len < shortest) shortest = len;
                runs++;
                len = 0;
                prev = byte_clk;
            end
            if (i == 20) begin
                cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 8'h00;
            end else begin
                cfg_we = 1'b0;
            end
        end
        check("R8", "shortest byte phase >= 2", (shortest >= 2) ? 1 : 0, 1);
    endtask

    initial begin
        int per, hi;
        repeat (3) @(negedge clk_vco);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", "byte_clk after reset", int'(byte_clk), 0);
        check("R1", "pix_clk after reset", int'(pix_clk), 1);
        check_byte("R1", 0, 0);
        hold_high("R1", 50);

        // R2 R3 R4 R5 R6 table walk
        for (int v = 0; v < NV; v++) begin
            wr(0, V_POST[v] | 8'hA0);
            wr(1, V_SEL[v] << 1);
            wr(2, V_PIX[v]);
            settle();
            check_byte((V_SEL[v] != 0) ? "R4" : "R3", V_POST[v], V_SEL[v]);
            check_pix("R5", V_PIX[v]);
        end

        // R7 pixel ratio rewritten right after a rise: current period keeps old length
        wr(2, 9);
        settle();
        wait_rise(1'b1);
        cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 8'd1;
        count_period(1'b1, per, hi);
        check("R7", "pix period during change", per, 10);
        check("R7", "pix high during change", hi, 5);
        count_period(1'b1, per, hi);
        check("R7", "pix period after change", per, 2);

        // R8 select change from 1 to 0 right after a byte rise
        wr(0, 15);
        wr(1, 2);
        settle();
        wait_rise(1'b0);
        cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 8'h00;
        count_period(1'b0, per, hi);
        check("R8", "byte high finishes at old rate", hi, 64);
        check("R8", "byte period across select change", per, 66);

        // R8 phase lengths across a 1 -> 0 switch at an arbitrary point
        wr(0, 3);
        wr(1, 2);
        settle();
        run_lengths(300);

        // R9 save, overwrite, restore
        wr(0, 2); wr(1, 2); wr(2, 4);
        save_i = 1'b1; @(negedge clk_vco); save_i = 1'b0;
        wr(0, 0); wr(1, 0); wr(2, 7);
        settle();
        check_byte("R9", 0, 0);
        check_pix("R9", 7);
        // restore in the same cycle as a pixel write: restore wins
        restore_i = 1'b1;
        cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 8'd50;
        @(negedge clk_vco);
        restore_i = 1'b0; cfg_we = 1'b0;
        settle();
        check_byte("R9", 2, 1);
        check_pix("R9", 4);

        // R10 write to the unused address
        wr(3, 8'hFF);
        settle();
        check_byte("R10", 2, 1);
        check_pix("R10", 4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk_vco);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule